// File: doc/BRIEF.md
# GCR Sector Header Decoder

This block watches a byte stream taken from a disk read channel and picks out sector headers. A header opens with a fixed three-byte sync sequence. Five group-coded bytes follow, then a fixed two-byte closing sequence. The block reverse-maps each coded byte to its 6-bit value and rebuilds the track number, sector number and side from those values. It checks the XOR checksum and the closing bytes, then hands one result word downstream. The result word carries an error flag. Bit alignment has already been done upstream, and the data field that follows a header is not handled here.

Bytes enter on a valid/ready interface. Results leave on a second valid/ready interface. A result is held on the output until the consumer takes it. While a result is held, `in_ready` stays low, so the producer must keep `in_byte` and `in_valid` steady until the byte is taken. A byte is taken on a rising clock edge where `in_valid` and `in_ready` are both high. A result is taken on a rising edge where `res_valid` and `res_ready` are both high. The track, sector and side fields mean something only when `res_err` is 0.

Top module: `gcr_hdr_decoder`

## Requirements
- R1: After reset, `res_valid` is 0, `in_ready` is 1, and the block is looking for the first sync byte 0xD5.
- R2: `in_ready` is low exactly while a result is pending. A pending result and its fields stay unchanged until a rising edge where `res_ready` is high; on that edge the result is consumed.
- R3: A result is produced only after the bytes 0xD5, 0xAA, 0x96 have been taken in that order with nothing between them.
- R4: If a sync sequence breaks off part way, the search starts again. If the byte that breaks it is 0xD5, that byte counts as the first byte of a new sync sequence.
- R5: A coded byte is legal when all of the following hold: bit 7 is 1; among bits 7..0, at most one adjacent pair of bits is 00; among bits 6..0, at least one adjacent pair of bits is 11; and the byte is neither 0xD5 nor 0xAA. This gives exactly 64 legal codes. Taken in ascending order they decode to 0..63, so 0x96 decodes to 0 and 0xFF decodes to 63.
- R6: If one of the five body bytes is not a legal code, the block raises an error result on the edge that takes that byte and then goes back to looking for 0xD5.
- R7: The five decoded body values must XOR to zero. If they do not, a header that is otherwise complete ends in an error result.
- R8: After the body, the block compares the next two bytes raw against 0xDE and then 0xAA. The first byte that does not match raises an error result, and the block goes back to looking for 0xD5. That byte is not reused as a sync byte.
- R9: For an error-free result, the fields are built from the decoded body values b0..b4 as follows: sector = b1; track[5:0] = b0; track[7:6] = b2[1:0]; side = b2[5].
- R10: `res_valid` goes high in the cycle right after the rising edge that takes the byte which completes or fails a header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A raw byte is offered |
| in_ready | output | 1 | The block can take a byte |
| in_byte | input | 8 | Raw disk byte |
| res_valid | output | 1 | A header result is pending |
| res_ready | input | 1 | The consumer takes the result |
| res_track | output | 8 | Decoded track number |
| res_sector | output | 6 | Decoded sector number |
| res_side | output | 1 | Decoded side |
| res_err | output | 1 | 1 if the header failed a code, checksum or closing-byte test |

## Verification
Every result, good or failed, is due exactly one cycle after the rising edge that takes its deciding byte. `in_ready` falls in the same cycle that `res_valid` rises. The bench's behavioural model works out its expected outputs from the bytes it knows were taken and the results it knows were consumed at each edge. It then compares `res_valid`, `in_ready`, the error flag and the fields against the design at the next falling edge. Both sides run under steady flow and under random gaps on both interfaces, so a result that arrives one cycle early or late, or that changes while it is held, shows up as a mismatch in that same cycle.

// File: rtl/gcr_hdr_pkg.sv
package gcr_hdr_pkg;

  localparam int CODE_W  = 8;
  localparam int VAL_W   = 6;
  localparam int BODY_N  = 5;
  localparam int TRK_W   = VAL_W + 2;
  localparam int IDX_W   = $clog2(BODY_N);
  localparam int SIDE_B  = 5;

  // byte values excluded from the code set regardless of bit pattern
  localparam logic [CODE_W-1:0] RSV_LO = 8'hAA;
  localparam logic [CODE_W-1:0] RSV_HI = 8'hD5;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_SYNC1,
    ST_SYNC2,
    ST_BODY,
    ST_END1,
    ST_END2
  } hdr_state_t;

  function automatic logic code_legal(input logic [CODE_W-1:0] c);
    int zeros;
    int ones;
    zeros = 0;
    ones  = 0;
    for (int j = 0; j < CODE_W - 1; j++) begin
      if (!c[j] && !c[j+1]) zeros++;
    end
    for (int j = 0; j < CODE_W - 2; j++) begin
      if (c[j] && c[j+1]) ones++;
    end
    return c[CODE_W-1] && (zeros <= 1) && (ones >= 1) &&
           (c != RSV_LO) && (c != RSV_HI);
  endfunction

  function automatic int code_rank(input logic [CODE_W-1:0] c);
    int r;
    r = 0;
    for (int k = 0; k < (1 << CODE_W); k++) begin
      if (k < int'(c) && code_legal(CODE_W'(k))) r++;
    end
    return r;
  endfunction

endpackage

// File: rtl/gcr_code_rom.sv
module gcr_code_rom
  import gcr_hdr_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic              ok,
  output logic [VAL_W-1:0]  val
);

  localparam int ENTRIES = 1 << CODE_W;

  logic [ENTRIES-1:0] ok_tbl;
  logic [VAL_W-1:0]   val_tbl [ENTRIES];

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      localparam logic             LEG = code_legal(CODE_W'(g));
      localparam logic [VAL_W-1:0] RNK = VAL_W'(code_rank(CODE_W'(g)));
      assign ok_tbl[g]  = LEG;
      assign val_tbl[g] = LEG ? RNK : '0;
    end
  endgenerate

  assign ok  = ok_tbl[code];
  assign val = val_tbl[code];

  // R5: any code the table accepts must carry the sync bit and avoid the reserved values
  always_comb begin
    if (ok) begin
      a_r5_code_msb: assert (code[CODE_W-1]);
      a_r5_not_reserved: assert (code != RSV_LO && code != RSV_HI);
    end
  end

endmodule

// File: rtl/gcr_hdr_fields.sv
module gcr_hdr_fields
  import gcr_hdr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  input  logic [VAL_W-1:0] val,
  output logic [TRK_W-1:0] track,
  output logic [VAL_W-1:0] sector,
  output logic             side,
  output logic             sum_ok
);

  logic [VAL_W-1:0] acc;
  logic [VAL_W-1:0] trk_lo;
  logic [1:0]       trk_hi;
  logic [VAL_W-1:0] sec_q;
  logic             side_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (clr) begin
      acc <= '0;
    end else if (wr) begin
      acc <= acc ^ val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_lo <= '0;
      trk_hi <= '0;
      sec_q  <= '0;
      side_q <= 1'b0;
    end else if (wr) begin
      case (idx)
        IDX_W'(0): trk_lo <= val;
        IDX_W'(1): sec_q  <= val;
        IDX_W'(2): begin
          trk_hi <= val[1:0];
          side_q <= val[SIDE_B];
        end
        default: ;
      endcase
    end
  end

  assign track  = {trk_hi, trk_lo};
  assign sector = sec_q;
  assign side   = side_q;
  assign sum_ok = (acc == '0);

endmodule

// File: rtl/gcr_hdr_fsm.sv
module gcr_hdr_fsm
  import gcr_hdr_pkg::*;
#(
  parameter logic [CODE_W-1:0] SYNC_A = 8'hD5,
  parameter logic [CODE_W-1:0] SYNC_B = 8'hAA,
  parameter logic [CODE_W-1:0] SYNC_C = 8'h96,
  parameter logic [CODE_W-1:0] END_A  = 8'hDE,
  parameter logic [CODE_W-1:0] END_B  = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [CODE_W-1:0] byte_in,
  input  logic              code_ok,
  input  logic              sum_ok,
  input  logic              res_ready,
  output logic              res_valid,
  output logic              res_err,
  output logic              fld_clr,
  output logic              fld_wr,
  output logic [IDX_W-1:0]  fld_idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BODY_N - 1);

  hdr_state_t       st, st_n;
  logic [IDX_W-1:0] cnt;
  logic             emit, emit_err;

  always_comb begin
    st_n     = st;
    emit     = 1'b0;
    emit_err = 1'b0;
    fld_clr  = 1'b0;
    fld_wr   = 1'b0;
    if (take) begin
      case (st)
        ST_HUNT: begin
          if (byte_in == SYNC_A) st_n = ST_SYNC1;
        end
        ST_SYNC1: begin
          if (byte_in == SYNC_B)      st_n = ST_SYNC2;
          else if (byte_in == SYNC_A) st_n = ST_SYNC1;
          else                        st_n = ST_HUNT;
        end
        ST_SYNC2: begin
          if (byte_in == SYNC_C) begin
            st_n    = ST_BODY;
            fld_clr = 1'b1;
          end else if (byte_in == SYNC_A) begin
            st_n = ST_SYNC1;
          end else begin
            st_n = ST_HUNT;
          end
        end
        ST_BODY: begin
          if (!code_ok) begin
            st_n     = ST_HUNT;
            emit     = 1'b1;
            emit_err = 1'b1;
          end else begin
            fld_wr = 1'b1;
            if (cnt == LAST_IDX) st_n = ST_END1;
          end
        end
        ST_END1: begin
          if (byte_in == END_A) begin
            st_n = ST_END2;
          end else begin
            st_n     = ST_HUNT;
            emit     = 1'b1;
            emit_err = 1'b1;
          end
        end
        ST_END2: begin
          st_n     = ST_HUNT;
          emit     = 1'b1;
          emit_err = (byte_in != END_B) || !sum_ok;
        end
        default: st_n = ST_HUNT;
      endcase
    end
  end

  assign fld_idx = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_HUNT;
      cnt <= '0;
    end else begin
      st <= st_n;
      if (fld_clr)     cnt <= '0;
      else if (fld_wr) cnt <= cnt + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_err   <= 1'b0;
    end else if (emit) begin
      res_valid <= 1'b1;
      res_err   <= emit_err;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R2: a held result does not change until consumed
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_err));

  // R10: a new result always follows a byte taken on the previous edge
  a_r10_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(take));

  // R3: the body is entered only through the last sync byte
  a_r3_body_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BODY && $past(st) != ST_BODY) |-> $past(take && byte_in == SYNC_C));

  // R6: an illegal body code yields an error result on the next cycle
  a_r6_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    take && st == ST_BODY && !code_ok |=> res_valid && res_err);

  // R8: a wrong first closing byte yields an error result
  a_r8_end_mark: assert property (@(posedge clk) disable iff (!rst_n)
    take && st == ST_END1 && byte_in != END_A |=> res_valid && res_err);

  // R7: with correct closing bytes the error flag follows the checksum
  a_r7_checksum: assert property (@(posedge clk) disable iff (!rst_n)
    take && st == ST_END2 && byte_in == END_B |=> res_valid && (res_err != $past(sum_ok)));

endmodule

// File: rtl/gcr_hdr_decoder.sv
module gcr_hdr_decoder
  import gcr_hdr_pkg::*;
#(
  parameter logic [CODE_W-1:0] SYNC_A = 8'hD5,
  parameter logic [CODE_W-1:0] SYNC_B = 8'hAA,
  parameter logic [CODE_W-1:0] SYNC_C = 8'h96,
  parameter logic [CODE_W-1:0] END_A  = 8'hDE,
  parameter logic [CODE_W-1:0] END_B  = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_byte,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [TRK_W-1:0]  res_track,
  output logic [VAL_W-1:0]  res_sector,
  output logic              res_side,
  output logic              res_err
);

  logic             take;
  logic             code_ok;
  logic [VAL_W-1:0] code_val;
  logic             sum_ok;
  logic             fld_clr, fld_wr;
  logic [IDX_W-1:0] fld_idx;

  assign in_ready = !res_valid;
  assign take     = in_valid && in_ready;

  gcr_code_rom u_rom (
    .code (in_byte),
    .ok   (code_ok),
    .val  (code_val)
  );

  gcr_hdr_fsm #(
    .SYNC_A (SYNC_A),
    .SYNC_B (SYNC_B),
    .SYNC_C (SYNC_C),
    .END_A  (END_A),
    .END_B  (END_B)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .byte_in   (in_byte),
    .code_ok   (code_ok),
    .sum_ok    (sum_ok),
    .res_ready (res_ready),
    .res_valid (res_valid),
    .res_err   (res_err),
    .fld_clr   (fld_clr),
    .fld_wr    (fld_wr),
    .fld_idx   (fld_idx)
  );

  gcr_hdr_fields u_fields (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (fld_clr),
    .wr     (fld_wr),
    .idx    (fld_idx),
    .val    (code_val),
    .track  (res_track),
    .sector (res_sector),
    .side   (res_side),
    .sum_ok (sum_ok)
  );

  // R2: fields of a pending result stay put until it is consumed
  a_r2_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> $stable(res_track) && $stable(res_sector) && $stable(res_side));

endmodule

// File: tb/tb_gcr_hdr_decoder.sv
`timescale 1ns/1ps
module tb_gcr_hdr_decoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_byte = 8'h00;
  logic       res_valid;
  logic       res_ready = 1'b0;
  logic [7:0] res_track;
  logic [5:0] res_sector;
  logic       res_side;
  logic       res_err;

  always #2.5 clk = ~clk;

  gcr_hdr_decoder dut (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready), .in_byte (in_byte),
    .res_valid (res_valid), .res_ready (res_ready),
    .res_track (res_track), .res_sector (res_sector),
    .res_side (res_side), .res_err (res_err)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  bit tbl_ok [256];
  int tbl_val [256];
  int enc [64];
  int n_legal;

  logic [7:0] q [$];
  int  ms, mn, msum;
  int  mv [5];
  bit  mvalid, merr;
  int  mtrack, msector, mside;
  bit  gap_mode, rr_mode;
  logic [15:0] lf = 16'hACE1;
  int  ngood, nbad;
  int  last_trk, last_sec, last_side;

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit spec_legal(input int c);
    int z, o;
    logic [7:0] b;
    b = 8'(c);
    z = 0; o = 0;
    for (int j = 0; j < 7; j++) if (b[j] == 1'b0 && b[j+1] == 1'b0) z++;
    for (int j = 0; j < 6; j++) if (b[j] == 1'b1 && b[j+1] == 1'b1) o++;
    return b[7] && z <= 1 && o >= 1 && b != 8'hD5 && b != 8'hAA;
  endfunction

  task automatic emit(input bit e);
    mvalid = 1'b1;
    merr = e;
    if (!e) begin
      mtrack  = ((mv[2] & 3) << 6) | mv[0];
      msector = mv[1];
      mside   = (mv[2] >> 5) & 1;
    end
  endtask

  task automatic model_step(input logic [7:0] b);
    case (ms)
      0: if (b == 8'hD5) ms = 1;
      1: ms = (b == 8'hAA) ? 2 : (b == 8'hD5) ? 1 : 0;
      2: begin
        if (b == 8'h96) begin ms = 3; mn = 0; msum = 0; end
        else ms = (b == 8'hD5) ? 1 : 0;
      end
      3: begin
        if (!tbl_ok[b]) begin emit(1'b1); ms = 0; end
        else begin
          mv[mn] = tbl_val[b];
          msum = msum ^ tbl_val[b];
          mn++;
          if (mn == 5) ms = 4;
        end
      end
      4: if (b == 8'hDE) ms = 5; else begin emit(1'b1); ms = 0; end
      default: begin emit(b != 8'hAA || msum != 0); ms = 0; end
    endcase
  endtask

  task automatic cycle();
    bit fin, fout;
    @(negedge clk);
    fin  = in_valid && !mvalid;
    fout = mvalid && res_ready;
    if (fout) mvalid = 1'b0;
    if (fin) begin
      void'(q.pop_front());
      model_step(in_byte);
    end
    chk("R2", int'(in_ready), int'(!mvalid), "in_ready");
    chk("R10", int'(res_valid), int'(mvalid), "res_valid");
    if (mvalid && res_valid) begin
      chk("R6 R7 R8", int'(res_err), int'(merr), "res_err");
      if (!merr) begin
        chk("R9", int'(res_track), mtrack, "track");
        chk("R9", int'(res_sector), msector, "sector");
        chk("R9", int'(res_side), mside, "side");
      end
    end
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    if (!(in_valid && !fin)) begin
      if (q.size() > 0 && (!gap_mode || lf[3])) begin
        in_valid = 1'b1;
        in_byte  = q[0];
      end else begin
        in_valid = 1'b0;
      end
    end
    res_ready = rr_mode ? lf[7] : 1'b1;
    if (res_valid && res_ready) begin
      if (res_err) nbad++;
      else begin
        ngood++;
        last_trk = res_track; last_sec = res_sector; last_side = res_side;
      end
    end
  endtask

  task automatic drain();
    while (q.size() > 0 || mvalid || in_valid || res_valid) cycle();
    repeat (3) cycle();
  endtask

  task automatic hdr(input int trk, input int sec, input int sd, input int mode);
    int d [5];
    d[0] = trk & 63;
    d[1] = sec & 63;
    d[2] = ((sd & 1) << 5) | ((trk >> 6) & 3);
    d[3] = (trk * 7 + sec) & 63;
    d[4] = d[0] ^ d[1] ^ d[2] ^ d[3];
    if (mode == 1) d[4] = d[4] ^ 1;
    q.push_back(8'hD5); q.push_back(8'hAA); q.push_back(8'h96);
    for (int i = 0; i < 5; i++) begin
      if (mode == 2 && i == 2) q.push_back(8'h95);
      else if (mode == 5 && i == 4) q.push_back(8'hAA);
      else q.push_back(8'(enc[d[i]]));
    end
    q.push_back(mode == 3 ? 8'hDF : 8'hDE);
    q.push_back(mode == 4 ? 8'hAB : 8'hAA);
  endtask

  task automatic expect_counts(input string tag, input int g, input int b);
    drain();
    chk(tag, ngood, g, "good results");
    chk(tag, nbad, b, "error results");
    ngood = 0; nbad = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    n_legal = 0;
    for (int c = 0; c < 256; c++) begin
      tbl_ok[c] = spec_legal(c);
      tbl_val[c] = 0;
      if (tbl_ok[c]) begin
        tbl_val[c] = n_legal;
        enc[n_legal] = c;
        n_legal++;
      end
    end
    ms = 0; mn = 0; msum = 0; mvalid = 0; merr = 0;
    gap_mode = 0; rr_mode = 0; ngood = 0; nbad = 0;
    // R5: code set size and endpoints of the ascending map
    chk("R5", n_legal, 64, "legal code count");
    chk("R5", enc[0], 8'h96, "code for 0");
    chk("R5", enc[63], 8'hFF, "code for 63");

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", int'(res_valid), 0, "res_valid after reset");
    chk("R1", int'(in_ready), 1, "in_ready after reset");
    res_ready = 1'b1;

    // R1: no sync start, so sync tail plus body yields nothing
    q.push_back(8'hAA); q.push_back(8'h96);
    for (int i = 0; i < 5; i++) q.push_back(8'hFF);
    q.push_back(8'hDE); q.push_back(8'hAA);
    expect_counts("R1", 0, 0);

    // R3 R9: junk then a clean header
    q.push_back(8'h00); q.push_back(8'hFF); q.push_back(8'h96); q.push_back(8'hAA);
    hdr(8'hC5, 17, 1, 0);
    expect_counts("R3", 1, 0);
    chk("R9", last_trk, 8'hC5, "track field");
    chk("R9", last_sec, 17, "sector field");
    chk("R9", last_side, 1, "side field");

    // R5: codes 0xFF and 0x96 at the map ends
    hdr(8'h3F, 0, 0, 0);
    expect_counts("R5", 1, 0);
    chk("R5", last_trk, 63, "track from 0xFF");
    chk("R5", last_sec, 0, "sector from 0x96");

    // R4: restart on broken sync, 0xD5 reused
    q.push_back(8'hD5); q.push_back(8'hAA);
    hdr(8'h12, 5, 0, 0);
    q.push_back(8'hD5);
    hdr(8'h40, 9, 1, 0);
    q.push_back(8'hD5); q.push_back(8'hAA); q.push_back(8'h97);
    for (int i = 0; i < 5; i++) q.push_back(8'hB5);
    q.push_back(8'hDE); q.push_back(8'hAA);
    expect_counts("R4", 2, 0);

    // R6: illegal body code, including a reserved value
    hdr(8'h21, 3, 0, 2);
    hdr(8'h22, 4, 1, 5);
    expect_counts("R6", 0, 2);

    // R7: checksum mismatch
    hdr(8'h7E, 11, 1, 1);
    expect_counts("R7", 0, 1);

    // R8: wrong first and second closing bytes
    hdr(8'h30, 2, 0, 3);
    hdr(8'h31, 6, 1, 4);
    expect_counts("R8", 0, 2);

    // R2 R10: gaps and back-pressure on both sides, mixed outcomes
    gap_mode = 1; rr_mode = 1;
    for (int k = 0; k < 24; k++) hdr((k * 37) & 255, (k * 5) & 63, k & 1, k % 6);
    expect_counts("R2", 4, 20);
    for (int k = 0; k < 16; k++) hdr((k * 53 + 9) & 255, (k * 11) & 63, (k >> 1) & 1, 0);
    expect_counts("R10", 16, 0);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule